// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital side of a 10-bit successive approximation converter. It turns a start request into a timed conversion. It divides the system clock down to an ADC clock and picks the moment to sample. It then walks a trial code past an external one-bit comparator, from the most significant bit down, and hands back a 10-bit result with a one-cycle done pulse. The analog DAC, the comparator and any gain stage sit outside. They see only `dac_code_o`, `sample_o` and `cmp_i`.

Each conversion lasts either 13 or 25 ADC clocks. The longer form gives the analog path time to settle after the block is switched on, after the reference choice changes, or after a new differential channel is chosen. Channel and reference requests are latched only when a conversion starts, so a change made mid-conversion waits for the next one. In free-running mode, back-to-back conversions follow one another with no gap. Conversions on a differential channel may only start on alternate ADC clock edges.

Top module: `adc_sar_sequencer`

## Requirements
- R1: The ADC clock is the system clock divided by 2 to the power `div_sel_i` (0..7). Its divider is held cleared while `en_i` is low and counts only while `en_i` is high.
- R2: A normal-length conversion takes 13 ADC clocks. With `div_sel_i`=0, a single-ended single conversion raises `done_o` 13 system clocks after the edge that captures `start_i`.
- R3: A conversion is extended to 25 ADC clocks when it is the first since `en_i` rose, when `ref_sel_i` differs from the last applied reference, or when `chan_sel_i` bit 2 is set (differential) and the channel differs from the last applied one. Repeated conversions on the same differential channel are normal length.
- R4: `sample_o` is a one-cycle pulse at the end of ADC clock 2 of a normal conversion or clock 14 of an extended one. It therefore comes exactly 11 ADC clocks before `done_o`.
- R5: The first trial code after the sample is 0x200. Each following ADC clock resolves one bit, MSB first, and keeps it when `cmp_i`=1 (input at or above the trial code). The result equals the input level for any level 0..1023.
- R6: A one on `start_i` makes `busy_o` read 1 from the next cycle. The conversion begins on the next ADC clock edge. In single mode `busy_o` clears in the same cycle that `done_o` pulses, and `done_o` is one system clock wide.
- R7: With a differential channel (`chan_sel_i` bit 2 = 1), a conversion starts only on odd-numbered ADC clock edges, counting the first edge after `en_i` rose as edge 1.
- R8: With `freerun_i`=1, `busy_o` stays high across each done and the next conversion begins at once, so consecutive `done_o` pulses are exactly one conversion length apart. Clearing `freerun_i` lets the current conversion finish, then `busy_o` clears.
- R9: `chan_act_o` and `ref_act_o` take the values of `chan_sel_i` and `ref_sel_i` only when a conversion starts. Changes made during a conversion do not show until the next start.
- R10: Dropping `en_i` aborts a conversion. `busy_o` is low on the next cycle and no `done_o` follows.
- R11: Holding `start_i` low has no effect. A `start_i` pulse during a conversion does not cause an extra conversion.
- R12: After reset, `busy_o`, `done_o`, `sample_o`, `result_o`, `dac_code_o`, `chan_act_o` and `ref_act_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Block enable; low aborts and clears the divider |
| start_i | input | 1 | Start request, one-cycle write of one |
| freerun_i | input | 1 | Free-running mode select |
| div_sel_i | input | 3 | ADC clock divide exponent |
| ref_sel_i | input | 2 | Requested reference choice |
| chan_sel_i | input | 3 | Requested channel; bit 2 marks differential |
| cmp_i | input | 1 | Comparator: 1 when input is at or above the trial code |
| dac_code_o | output | 10 | Trial code for the DAC |
| sample_o | output | 1 | Sample-and-hold strobe |
| result_o | output | 10 | Last conversion result |
| done_o | output | 1 | One-cycle pulse when a result is written |
| busy_o | output | 1 | Start/busy bit |
| chan_act_o | output | 3 | Channel applied to the running conversion |
| ref_act_o | output | 2 | Reference applied to the running conversion |

## Verification
The bench goes after the length decision: the first conversion after enable, a reference change, a switch to a new differential channel and a repeat on the same one. A design that misjudged any of these would put `done_o` 12 clocks early or late. Differential starts are issued on both even and odd ADC edges. A design that ignored alignment would start one clock early, and one that always waited would start one clock late. Input levels 0, 511, 512 and 1023, plus random ones, expose a comparator polarity or bit-order slip as a wrong result. Mid-conversion selection changes, aborts, repeated start writes and free-running at two divide ratios catch early selection updates, a done after abort, duplicate conversions and a gap or overlap between free-running results.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
    localparam int SAR_RES_W      = 10;
    localparam int SAR_NORM_LEN   = 13;
    localparam int SAR_EXT_LEN    = 25;
    localparam int SAR_DIV_STAGES = 7;
    localparam int SAR_CHAN_W     = 3;
    localparam int SAR_REF_W      = 2;
endpackage

// File: rtl/sar_prescaler.sv
module sar_prescaler #(
    parameter int DIV_STAGES = sar_seq_pkg::SAR_DIV_STAGES,
    parameter int SEL_W      = $clog2(DIV_STAGES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    logic [DIV_STAGES-1:0] cnt_d, cnt_q;
    logic [DIV_STAGES-1:0] mask;

    // Low sel_i bits of the counter must all be one for an ADC clock edge.
    always_comb begin
        for (int i = 0; i < DIV_STAGES; i++) begin
            mask[i] = (i < int'(sel_i));
        end
    end

    always_comb begin
        cnt_d  = en_i ? cnt_q + 1'b1 : '0;
        tick_o = en_i && ((cnt_q & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R1: divider is held cleared while disabled
    p_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (cnt_q == '0));
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
    parameter int RES_W = sar_seq_pkg::SAR_RES_W,
    parameter int IDX_W = $clog2(RES_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             load_i,
    input  logic             step_i,
    input  logic             cmp_i,
    output logic [RES_W-1:0] code_o
);
    typedef struct packed {
        logic [RES_W-1:0] code;
        logic [IDX_W-1:0] idx;
    } trial_t;

    localparam logic [RES_W-1:0] FIRST_TRIAL = RES_W'(1) << (RES_W - 1);

    trial_t d, q;

    always_comb begin
        d = q;
        if (clr_i) begin
            d.code = '0;
            d.idx  = '0;
        end else if (load_i) begin
            d.code = FIRST_TRIAL;
            d.idx  = IDX_W'(RES_W - 1);
        end else if (step_i) begin
            if (!cmp_i) d.code[q.idx] = 1'b0;
            if (q.idx != '0) begin
                d.code[q.idx - 1'b1] = 1'b1;
                d.idx                = q.idx - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign code_o = q.code;

    // R5: a fresh approximation always opens with the MSB trial
    p_msb_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !clr_i) |=> (code_o == FIRST_TRIAL));
endmodule

// File: rtl/adc_sar_sequencer.sv
module adc_sar_sequencer #(
    parameter int RES_W      = sar_seq_pkg::SAR_RES_W,
    parameter int NORM_LEN   = sar_seq_pkg::SAR_NORM_LEN,
    parameter int EXT_LEN    = sar_seq_pkg::SAR_EXT_LEN,
    parameter int DIV_STAGES = sar_seq_pkg::SAR_DIV_STAGES,
    parameter int CHAN_W     = sar_seq_pkg::SAR_CHAN_W,
    parameter int REF_W      = sar_seq_pkg::SAR_REF_W,
    parameter int SEL_W      = $clog2(DIV_STAGES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              start_i,
    input  logic              freerun_i,
    input  logic [SEL_W-1:0]  div_sel_i,
    input  logic [REF_W-1:0]  ref_sel_i,
    input  logic [CHAN_W-1:0] chan_sel_i,
    input  logic              cmp_i,
    output logic [RES_W-1:0]  dac_code_o,
    output logic              sample_o,
    output logic [RES_W-1:0]  result_o,
    output logic              done_o,
    output logic              busy_o,
    output logic [CHAN_W-1:0] chan_act_o,
    output logic [REF_W-1:0]  ref_act_o
);
    localparam int STEP_W = $clog2(EXT_LEN + 1);
    // Sample lands two clocks before the RES_W bit trials and the final clock.
    localparam logic [STEP_W-1:0] N_SAMP = STEP_W'(NORM_LEN - RES_W - 2);
    localparam logic [STEP_W-1:0] E_SAMP = STEP_W'(EXT_LEN - RES_W - 2);
    localparam logic [STEP_W-1:0] N_LAST = STEP_W'(NORM_LEN - 1);
    localparam logic [STEP_W-1:0] E_LAST = STEP_W'(EXT_LEN - 1);

    typedef struct packed {
        logic              pend;
        logic              busy;
        logic              longc;
        logic [STEP_W-1:0] step;
        logic              parity;
        logic              first;
        logic [REF_W-1:0]  ref_act;
        logic [CHAN_W-1:0] chan_act;
        logic [RES_W-1:0]  result;
        logic              done;
        logic              sample;
    } seq_t;

    seq_t d, q;

    logic              tick;
    logic [RES_W-1:0]  code;
    logic [STEP_W-1:0] samp_step, last_step;
    logic              diff_req, ext_need, done_tick, start_ok, launch;
    logic              trial_load, trial_step;

    sar_prescaler #(
        .DIV_STAGES (DIV_STAGES),
        .SEL_W      (SEL_W)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en_i),
        .sel_i  (div_sel_i),
        .tick_o (tick)
    );

    sar_trial_reg #(
        .RES_W (RES_W)
    ) u_trial (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (!en_i),
        .load_i (trial_load),
        .step_i (trial_step),
        .cmp_i  (cmp_i),
        .code_o (code)
    );

    always_comb begin
        samp_step  = q.longc ? E_SAMP : N_SAMP;
        last_step  = q.longc ? E_LAST : N_LAST;
        diff_req   = chan_sel_i[CHAN_W-1];
        ext_need   = q.first || (ref_sel_i != q.ref_act)
                     || (diff_req && (chan_sel_i != q.chan_act));
        done_tick  = tick && q.busy && (q.step == last_step);
        start_ok   = tick && !q.busy && q.pend && (!diff_req || !q.parity);
        launch     = start_ok || (done_tick && freerun_i);
        trial_load = tick && q.busy && (q.step == samp_step);
        trial_step = tick && q.busy && (q.step > samp_step) && (q.step < last_step);
    end

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.sample = 1'b0;
        if (!en_i) begin
            d.pend   = 1'b0;
            d.busy   = 1'b0;
            d.step   = '0;
            d.parity = 1'b0;
            d.first  = 1'b1;
        end else begin
            if (start_i && !q.busy) d.pend = 1'b1;
            if (tick) begin
                d.parity = ~q.parity;
                if (q.busy) begin
                    d.step = q.step + 1'b1;
                    if (q.step == samp_step) d.sample = 1'b1;
                end
                if (done_tick) begin
                    d.result = code;
                    d.done   = 1'b1;
                    d.busy   = 1'b0;
                end
                if (launch) begin
                    d.busy     = 1'b1;
                    d.pend     = 1'b0;
                    d.step     = start_ok ? STEP_W'(1) : '0;
                    d.longc    = ext_need;
                    d.first    = 1'b0;
                    d.ref_act  = ref_sel_i;
                    d.chan_act = chan_sel_i;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.first <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign dac_code_o = code;
    assign sample_o   = q.sample;
    assign result_o   = q.result;
    assign done_o     = q.done;
    assign busy_o     = q.busy || q.pend;
    assign chan_act_o = q.chan_act;
    assign ref_act_o  = q.ref_act;

    // R10: disabling kills any conversion with no result
    p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!busy_o && !done_o));

    // R6: done is a single-cycle pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: after a done, busy follows the mode that was in force
    p_mode_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_o == $past(freerun_i)));

    // R4: the sample strobe only occurs inside a conversion
    p_sample_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |-> busy_o);
endmodule

// File: tb/adc_sar_sequencer_bench.sv
module adc_sar_sequencer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       start = 1'b0;
    logic       freerun = 1'b0;
    logic [2:0] div_sel = '0;
    logic [1:0] ref_sel = '0;
    logic [2:0] chan_sel = '0;
    logic       cmp;
    logic [9:0] vin = '0;
    logic [9:0] dac_code, result;
    logic       sample, done, busy;
    logic [2:0] chan_act;
    logic [1:0] ref_act;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int cyc_en = 0;
    bit finished = 0;

    bit         m_first = 1;
    logic [1:0] m_ref = '0;
    logic [2:0] m_chan = '0;

    adc_sar_sequencer u_adc_sar_sequencer (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en),
        .start_i    (start),
        .freerun_i  (freerun),
        .div_sel_i  (div_sel),
        .ref_sel_i  (ref_sel),
        .chan_sel_i (chan_sel),
        .cmp_i      (cmp),
        .dac_code_o (dac_code),
        .sample_o   (sample),
        .result_o   (result),
        .done_o     (done),
        .busy_o     (busy),
        .chan_act_o (chan_act),
        .ref_act_o  (ref_act)
    );

    // Ideal comparator: one when the input is at or above the trial code.
    assign cmp = (vin >= dac_code);

    always #10 clk = ~clk;
    always @(posedge clk) cyc++;

    always @(posedge clk) begin
        if (cyc == 150000 && !finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int conv_len(input bit ext);
        return ext ? 25 : 13;
    endfunction

    task automatic enable_on();
        @(negedge clk);
        en = 1'b1;
        cyc_en = cyc;
        m_first = 1;
    endtask

    task automatic wait_done(output int dc);
        dc = -1;
        for (int i = 0; i < 600 && dc < 0; i++) begin
            @(negedge clk);
            if (done) dc = cyc;
        end
    endtask

    // One single-mode conversion with exact timing checks (div_sel must be 0).
    task automatic single(input logic [9:0] v, input logic [1:0] r, input logic [2:0] c);
        bit ext, diff;
        int c0, s, len, exp_done, got_done, got_samp;
        @(negedge clk);
        vin = v; ref_sel = r; chan_sel = c; start = 1'b1;
        c0 = cyc;
        diff = c[2];
        ext = m_first || (r != m_ref) || (diff && (c != m_chan));
        m_first = 0; m_ref = r; m_chan = c;
        s = c0 + 2;
        if (diff && (((s - cyc_en) % 2) == 0)) s++;
        len = conv_len(ext);
        exp_done = s + len - 1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R6", "busy after start", busy, 1);
        got_done = -1; got_samp = -1;
        for (int i = 0; i < 80 && got_done < 0; i++) begin
            if (sample && got_samp < 0) got_samp = cyc;
            if (done) got_done = cyc;
            else @(negedge clk);
        end
        if (diff) chk(got_done == exp_done, "R7", "done cycle", got_done, exp_done);
        else if (ext) chk(got_done == exp_done, "R3", "done cycle", got_done, exp_done);
        else chk(got_done == exp_done, "R2", "done cycle", got_done, exp_done);
        chk(got_samp == exp_done - 11, "R4", "sample cycle", got_samp, exp_done - 11);
        chk(result == v, "R5", "result", result, v);
        chk(busy == 1'b0, "R6", "busy at done", busy, 0);
    endtask

    initial begin
        int d1, d2, d3, d4, d5, nd;
        logic [1:0] r_new;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk(busy == 0 && done == 0 && sample == 0, "R12", "flags", {busy, done, sample}, 0);
        chk(result == 0 && dac_code == 0, "R12", "codes", result | dac_code, 0);
        chk(chan_act == 0 && ref_act == 0, "R12", "applied sel", {chan_act, ref_act}, 0);

        enable_on();
        // R11: idle start low does nothing
        nd = 0;
        repeat (40) begin @(negedge clk); if (done || busy) nd++; end
        chk(nd == 0, "R11", "activity with start low", nd, 0);

        // R3 first after enable, then R2 normal; edge levels for R5
        single(10'd512, 2'd0, 3'd0);
        single(10'd511, 2'd0, 3'd0);
        single(10'd0,   2'd0, 3'd1);
        single(10'd1023,2'd0, 3'd2);
        single(10'd700, 2'd1, 3'd2);  // R3 reference change
        single(10'd300, 2'd1, 3'd6);  // R3 new differential channel
        single(10'd301, 2'd1, 3'd6);  // R3 repeat differential is normal
        single(10'd302, 2'd1, 3'd7);
        @(negedge clk);               // shift phase for R7 alignment
        single(10'd303, 2'd1, 3'd7);

        for (int k = 0; k < 24; k++) begin
            logic [1:0] rr;
            rr = (($urandom % 4) == 0) ? 2'($urandom) : m_ref;
            repeat ($urandom % 3) @(negedge clk);
            single(10'($urandom), rr, 3'($urandom));
        end

        // R9: selections deferred until the next start
        @(negedge clk);
        chan_sel = 3'd1; ref_sel = m_ref; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        m_chan = 3'd1; m_first = 0;
        repeat (3) @(negedge clk);
        r_new = m_ref ^ 2'd1;
        chan_sel = 3'd2; ref_sel = r_new;
        chk(chan_act == 3'd1, "R9", "chan mid-conversion", chan_act, 1);
        chk(ref_act == m_ref, "R9", "ref mid-conversion", ref_act, m_ref);
        wait_done(d1);
        chk(chan_act == 3'd1, "R9", "chan at done", chan_act, 1);
        single(10'd77, r_new, 3'd2);
        chk(chan_act == 3'd2 && ref_act == r_new, "R9", "applied after start",
            {chan_act, ref_act}, {3'd2, r_new});

        // R11: extra start during a conversion is ignored
        @(negedge clk);
        chan_sel = 3'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        nd = 0;
        repeat (100) begin @(negedge clk); if (done) nd++; end
        chk(nd == 1, "R11", "dones for two starts", nd, 1);
        chk(busy == 0, "R11", "busy after", busy, 0);
        m_chan = 3'd0;

        // R1 / R8: free-running at two divide ratios
        @(negedge clk);
        vin = 10'd613; freerun = 1'b1; div_sel = 3'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(d1);
        chk(busy == 1, "R8", "busy stays at done", busy, 1);
        wait_done(d2);
        chk(d2 - d1 == 52, "R1", "spacing at /4", d2 - d1, 52);
        chk(result == 10'd613, "R5", "free-run result", result, 613);
        @(negedge clk);
        div_sel = 3'd3;
        wait_done(d3);
        wait_done(d4);
        chk(d4 - d3 == 104, "R8", "spacing at /8", d4 - d3, 104);
        freerun = 1'b0;
        wait_done(d5);
        chk(busy == 0, "R8", "stop after freerun cleared", busy, 0);
        chk(result == 10'd613, "R5", "last free-run result", result, 613);
        div_sel = 3'd0;

        // R10: abort by disable, then first conversion is extended again
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk(busy == 0, "R10", "busy after disable", busy, 0);
        nd = 0;
        repeat (40) begin @(negedge clk); if (done) nd++; end
        chk(nd == 0, "R10", "done after abort", nd, 0);
        enable_on();
        single(10'd900, m_ref, 3'd0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule